// File: doc/BRIEF.md
# DMA Window Address Translator

This block maps a DMA address seen on the peripheral bus to a system memory address. Four programmable windows each carry a base, a size mask and a translated base, and each is either direct-mapped or scatter-gather. A scatter-gather hit reads one 64-bit page table entry through a single-beat memory read port and builds the result from it. Two fixed paths complete the decode. One is an identity window for a band of 64-bit addresses. The other is a 64-bit table-walk path owned by the last window. A control bit can also punch a hole in the low address space so that nothing inside it matches.

One request is handled at a time. The caller presents an address with `req_valid` while `busy` is low. The block answers with a one-cycle `done` pulse that carries either a translated address or a fault. The window and control registers are plain inputs, held stable by their owner, and the block keeps only their defined bits.

Top module: `dxl_translator`

## Requirements
- R1: Only defined register bits take effect. A window base uses bit 0 (enable), bit 1 (table mode) and bits 31:20 (base field), and the last window also uses bit 39 (wide-address enable). A mask uses bits 31:20. A translated base uses bits 34:10. Every other bit has no effect on any result.
- R2: The last window always translates through the page table, whatever its bit 1 holds.
- R3: For an address below 2^32, a window hits when it is enabled and the address, with the bits under (mask OR 0xFFFFF) cleared, equals the base field in bits 31:20.
- R4: A direct-mapped hit returns (translated base AND NOT ext) OR (address AND ext), where ext = mask OR 0xFFFFF.
- R5: A table-mode hit issues exactly one read at (translated base AND NOT (mask >> 10)) OR ((address AND (mask OR 0xFE000)) >> 10).
- R6: A page table entry is valid when its bit 0 is 1. The result is then entry bits 21:1 placed at address bits 33:13, with address bits 12:0 passed through. All other entry bits are ignored. An invalid entry gives a fault.
- R7: When the hole enable is set, an address from 0x80000 to 0xFFFFF faults without any window match.
- R8: Below 2^32 the windows are tried in index order 0, 1, 2 and the lowest hit wins. The last window takes part only while its wide-address enable (base bit 39) is clear.
- R9: When the identity enable is set, an address from 0x100_0000_0000 to 0x1FF_FFFF_FFFF returns its own low 35 bits.
- R10: An address from 0x800_0000_0000 to 0xFFF_FFFF_FFFF uses the last window only when both its enable and its wide-address enable are set. The entry is then read at (translated base AND 0x7FFC00000) OR ((address AND 0xFFFFE000) >> 10), and R6 applies.
- R11: A request that no path accepts completes with fault = 1 and a zero address.
- R12: After reset `busy`, `done` and `mem_req` are 0. A non-table result gives `done` in the cycle after acceptance. A table request holds `busy` until the read response arrives, and `done` follows one cycle later. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | ADDR_W | DMA address to translate |
| busy | output | 1 | A table read is outstanding |
| win_base | input | NWIN*40 | Window base registers, window 0 in the low slice |
| win_mask | input | NWIN*32 | Window size masks |
| win_tbase | input | NWIN*PA_W | Window translated bases |
| hole_en | input | 1 | Enables the low-address hole |
| ident_en | input | 1 | Enables the identity window |
| mem_req | output | 1 | One-cycle page table read request |
| mem_addr | output | PA_W | Page table entry address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | PTE_W | Page table entry |
| done | output | 1 | Result pulse |
| fault | output | 1 | The translation failed (valid with done) |
| xlat_addr | output | PA_W | System address (valid with done) |

## Verification
The bench builds the block at its defaults: four windows, a 44-bit DMA address, a 35-bit system address and a 64-bit entry. That width brings both the identity band and the wide table band within reach, so the fixed paths can be driven next to the windowed ones. With four windows there is room for an overlap where window 0 shadows window 2 until window 0 is disabled. Its memory model answers after three cycles, which leaves a busy interval in which a stray request can be offered and must be ignored.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
   localparam int BASE_W     = 40;
   localparam int MASK_W     = 32;
   localparam int WIDE_BIT   = 39;
   localparam int PAGE_OFF_W = 13;

   typedef enum logic [1:0] {
      RT_FAULT  = 2'd0,
      RT_DIRECT = 2'd1,
      RT_TABLE  = 2'd2
   } route_e;

   typedef enum logic {
      S_IDLE = 1'b0,
      S_WAIT = 1'b1
   } seq_e;
endpackage

// File: rtl/dxl_window.sv
module dxl_window
   import dxl_pkg::*;
#(
   parameter int PA_W     = 35,
   parameter bit FORCE_SG = 1'b0
) (
   input  logic [BASE_W-1:0] base_raw,
   input  logic [MASK_W-1:0] mask_raw,
   input  logic [PA_W-1:0]   tbase_raw,
   input  logic [31:0]       addr,
   output logic              hit,
   output logic              sg,
   output logic [PA_W-1:0]   direct_pa,
   output logic [PA_W-1:0]   pte_pa
);
   localparam logic [BASE_W-1:0] BASE_FIELD = 40'h00_FFF0_0000;
   localparam logic [63:0]       TB_KEEP64  = 64'h0000_0007_FFFF_FC00;
   localparam logic [PA_W-1:0]   TB_KEEP    = TB_KEEP64[PA_W-1:0];

   logic [MASK_W-1:0] mask_k;
   logic [31:0]       ext;
   logic [PA_W-1:0]   tb_k;
   logic              en;

   assign mask_k = mask_raw & 32'hFFF0_0000;
   assign ext    = mask_k | 32'h000F_FFFF;
   assign tb_k   = tbase_raw & TB_KEEP;
   assign en     = (base_raw & 40'h1) != '0;

   generate
      if (FORCE_SG) begin : g_sg_fixed
         assign sg = 1'b1;
      end else begin : g_sg_reg
         assign sg = (base_raw & 40'h2) != '0;
      end
   endgenerate

   assign hit       = en && (BASE_W'(addr & ~ext) == (base_raw & BASE_FIELD));
   assign direct_pa = (tb_k & ~PA_W'(ext)) | PA_W'(addr & ext);
   assign pte_pa    = (tb_k & ~PA_W'(mask_k >> 10))
                    | PA_W'((addr & (mask_k | 32'h000F_E000)) >> 10);
endmodule

// File: rtl/dxl_route.sv
module dxl_route
   import dxl_pkg::*;
#(
   parameter int NWIN   = 4,
   parameter int ADDR_W = 44,
   parameter int PA_W   = 35
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 hole_en,
   input  logic                 ident_en,
   input  logic [NWIN-1:0]      win_hit,
   input  logic [NWIN-1:0]      win_sg,
   input  logic [NWIN*PA_W-1:0] win_direct,
   input  logic [NWIN*PA_W-1:0] win_pte,
   input  logic                 wide_on,
   input  logic                 wide_win_en,
   input  logic [PA_W-1:0]      wide_tbase,
   output route_e               kind,
   output logic [PA_W-1:0]      pa
);
   localparam logic [63:0]     WIDE_KEEP64 = 64'h0000_0007_FFC0_0000;
   localparam logic [PA_W-1:0] WIDE_KEEP   = WIDE_KEEP64[PA_W-1:0];

   logic short_addr, in_hole, ident_band, wide_band;

   assign short_addr = (addr >> 32) == '0;
   assign in_hole    = (addr[31:0] >= 32'h0008_0000) && (addr[31:0] <= 32'h000F_FFFF);
   assign ident_band = (addr >> 40) == ADDR_W'(1);
   assign wide_band  = (addr >> 43) == ADDR_W'(1);

   always_comb begin
      kind = RT_FAULT;
      pa   = '0;
      if (short_addr) begin
         if (!(hole_en && in_hole)) begin
            // descending scan: the lowest index that hits is written last
            for (int i = NWIN - 1; i >= 0; i--) begin
               if (win_hit[i] && !((i == NWIN - 1) && wide_on)) begin
                  kind = win_sg[i] ? RT_TABLE : RT_DIRECT;
                  pa   = win_sg[i] ? win_pte[i*PA_W +: PA_W] : win_direct[i*PA_W +: PA_W];
               end
            end
         end
      end else if (ident_en && ident_band) begin
         kind = RT_DIRECT;
         pa   = addr[PA_W-1:0];
      end else if (wide_band && wide_on && wide_win_en) begin
         kind = RT_TABLE;
         pa   = (wide_tbase & WIDE_KEEP) | PA_W'((addr[31:0] & 32'hFFFF_E000) >> 10);
      end
   end

   AST_HOLE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (short_addr && hole_en && in_hole) |-> (kind == RT_FAULT)); // R7
   AST_WIDE_HIDES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (short_addr && wide_on && !(|win_hit[NWIN-2:0])) |-> (kind == RT_FAULT)); // R8
   AST_IDENT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (!short_addr && ident_en && ident_band) |-> (kind == RT_DIRECT && pa == addr[PA_W-1:0])); // R9
   AST_HIGH_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!short_addr && !ident_band && !wide_band) |-> (kind == RT_FAULT)); // R11
endmodule

// File: rtl/dxl_seq.sv
module dxl_seq
   import dxl_pkg::*;
#(
   parameter int PA_W  = 35,
   parameter int PTE_W = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  route_e                kind,
   input  logic [PA_W-1:0]       pa_in,
   input  logic [PAGE_OFF_W-1:0] page_off,
   output logic                  mem_req,
   output logic [PA_W-1:0]       mem_addr,
   input  logic                  mem_rsp_valid,
   input  logic [PTE_W-1:0]      mem_rsp_data,
   output logic                  busy,
   output logic                  done,
   output logic                  fault,
   output logic [PA_W-1:0]       xlat_addr
);
   localparam logic [63:0]      FRAME64 = 64'h0000_0000_003F_FFFE;
   localparam logic [PTE_W-1:0] FRAME   = FRAME64[PTE_W-1:0];

   seq_e                  state;
   logic [PAGE_OFF_W-1:0] off_q;

   assign busy = (state == S_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         off_q     <= '0;
         mem_req   <= 1'b0;
         mem_addr  <= '0;
         done      <= 1'b0;
         fault     <= 1'b0;
         xlat_addr <= '0;
      end else begin
         done    <= 1'b0;
         mem_req <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req_valid) begin
                  case (kind)
                     RT_DIRECT: begin
                        done      <= 1'b1;
                        fault     <= 1'b0;
                        xlat_addr <= pa_in;
                     end
                     RT_TABLE: begin
                        mem_req  <= 1'b1;
                        mem_addr <= pa_in;
                        off_q    <= page_off;
                        state    <= S_WAIT;
                     end
                     default: begin
                        done      <= 1'b1;
                        fault     <= 1'b1;
                        xlat_addr <= '0;
                     end
                  endcase
               end
            end
            S_WAIT: begin
               if (mem_rsp_valid) begin
                  done  <= 1'b1;
                  state <= S_IDLE;
                  if (mem_rsp_data[0]) begin
                     fault     <= 1'b0;
                     xlat_addr <= PA_W'(((mem_rsp_data & FRAME) << 12) | PTE_W'(off_q));
                  end else begin
                     fault     <= 1'b1;
                     xlat_addr <= '0;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (xlat_addr == '0)); // R11
   AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R5
   AST_WAIT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_rsp_valid) |=> !done); // R12
   AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && $past(busy)) |-> (xlat_addr[PAGE_OFF_W-1:0] == off_q)); // R6
endmodule

// File: rtl/dxl_translator.sv
module dxl_translator
   import dxl_pkg::*;
#(
   parameter int NWIN   = 4,
   parameter int ADDR_W = 44,
   parameter int PA_W   = 35,
   parameter int PTE_W  = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [ADDR_W-1:0]      req_addr,
   output logic                   busy,
   input  logic [NWIN*BASE_W-1:0] win_base,
   input  logic [NWIN*MASK_W-1:0] win_mask,
   input  logic [NWIN*PA_W-1:0]   win_tbase,
   input  logic                   hole_en,
   input  logic                   ident_en,
   output logic                   mem_req,
   output logic [PA_W-1:0]        mem_addr,
   input  logic                   mem_rsp_valid,
   input  logic [PTE_W-1:0]       mem_rsp_data,
   output logic                   done,
   output logic                   fault,
   output logic [PA_W-1:0]        xlat_addr
);
   localparam int LAST = NWIN - 1;

   generate
      if (NWIN < 2)                    begin : g_bad_nwin  $error("NWIN must be at least 2");           end
      if (ADDR_W < 44 || ADDR_W > 64)  begin : g_bad_addr  $error("ADDR_W must be within 44..64");    end
      if (PA_W < 35 || PA_W > ADDR_W)  begin : g_bad_pa    $error("PA_W must be within 35..ADDR_W");  end
      if (PTE_W < 22 || PTE_W > 64)    begin : g_bad_pte   $error("PTE_W must be within 22..64");     end
   endgenerate

   logic [NWIN-1:0]      win_hit, win_sg;
   logic [NWIN*PA_W-1:0] win_direct, win_pte;
   route_e               kind;
   logic [PA_W-1:0]      route_pa;

   generate
      for (genvar g = 0; g < NWIN; g++) begin : g_win
         dxl_window #(
            .PA_W     (PA_W),
            .FORCE_SG (g == LAST)
         ) u_win (
            .base_raw  (win_base[g*BASE_W +: BASE_W]),
            .mask_raw  (win_mask[g*MASK_W +: MASK_W]),
            .tbase_raw (win_tbase[g*PA_W +: PA_W]),
            .addr      (req_addr[31:0]),
            .hit       (win_hit[g]),
            .sg        (win_sg[g]),
            .direct_pa (win_direct[g*PA_W +: PA_W]),
            .pte_pa    (win_pte[g*PA_W +: PA_W])
         );
      end
   endgenerate

   dxl_route #(.NWIN(NWIN), .ADDR_W(ADDR_W), .PA_W(PA_W)) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (req_addr),
      .hole_en     (hole_en),
      .ident_en    (ident_en),
      .win_hit     (win_hit),
      .win_sg      (win_sg),
      .win_direct  (win_direct),
      .win_pte     (win_pte),
      .wide_on     (win_base[LAST*BASE_W + WIDE_BIT]),
      .wide_win_en (win_base[LAST*BASE_W]),
      .wide_tbase  (win_tbase[LAST*PA_W +: PA_W]),
      .kind        (kind),
      .pa          (route_pa)
   );

   dxl_seq #(.PA_W(PA_W), .PTE_W(PTE_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .kind          (kind),
      .pa_in         (route_pa),
      .page_off      (req_addr[PAGE_OFF_W-1:0]),
      .mem_req       (mem_req),
      .mem_addr      (mem_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .busy          (busy),
      .done          (done),
      .fault         (fault),
      .xlat_addr     (xlat_addr)
   );
endmodule

// File: tb/dxl_translator_tb.sv
`timescale 1ns/1ps
module dxl_translator_tb;
   localparam int NWIN = 4, ADDR_W = 44, PA_W = 35, PTE_W = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic busy, mem_req, done, fault;
   logic [PA_W-1:0] mem_addr, xlat_addr;
   logic mem_rsp_valid = 1'b0;
   logic [PTE_W-1:0] mem_rsp_data = '0;
   logic hole_en = 1'b0, ident_en = 1'b0;
   logic [39:0] b_r [4];
   logic [31:0] m_r [4];
   logic [34:0] t_r [4];
   logic [NWIN*40-1:0] win_base;
   logic [NWIN*32-1:0] win_mask;
   logic [NWIN*PA_W-1:0] win_tbase;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NWIN; i++) begin
         win_base[i*40 +: 40]    = b_r[i];
         win_mask[i*32 +: 32]    = m_r[i];
         win_tbase[i*PA_W +: PA_W] = t_r[i];
      end
   end

   dxl_translator #(.NWIN(NWIN), .ADDR_W(ADDR_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
      .win_base(win_base), .win_mask(win_mask), .win_tbase(win_tbase),
      .hole_en(hole_en), .ident_en(ident_en), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .fault(fault), .xlat_addr(xlat_addr)
   );

   int checks = 0, failures = 0, pushed = 0, seen = 0;
   bit finished = 0;

   // memory model: page table entry content, valid when address bit 3 is clear
   function automatic logic [63:0] pte_of(input logic [63:0] a);
      return (64'hABCD << 40) | (((a ^ 64'h2A5A5) << 1) & 64'h3F_FFFE) | {63'b0, ~a[3]};
   endfunction

   logic rv1 = 0, rv2 = 0;
   logic [PA_W-1:0] ra1 = '0, ra2 = '0, last_mem_addr = '0;
   always @(posedge clk) begin
      rv1 <= mem_req; ra1 <= mem_addr;
      rv2 <= rv1;     ra2 <= ra1;
      mem_rsp_valid <= rv2;
      mem_rsp_data  <= pte_of(64'(ra2));
      if (mem_req) last_mem_addr <= mem_addr;
   end

   function automatic void table_result(input logic [63:0] pte_a, input logic [63:0] a,
                                        output logic f, output logic [63:0] pa);
      logic [63:0] e;
      e = pte_of(pte_a);
      if (e[0]) begin f = 0; pa = ((e & 64'h3F_FFFE) << 12) | (a & 64'h1FFF); end
      else begin f = 1; pa = 0; end
   endfunction

   // reference model built from the requirements
   function automatic void model(input logic [63:0] a, output logic f, output logic [63:0] pa,
                                 output bit use_pte, output logic [63:0] pte_a);
      logic [63:0] bk, mk, ext, tb;
      f = 1; pa = 0; use_pte = 0; pte_a = 0;
      if (a <= 64'hFFFF_FFFF) begin
         if (hole_en && a >= 64'h8_0000 && a < 64'h10_0000) return;       // R7
         for (int i = 0; i < 4; i++) begin
            bk = 64'(b_r[i]) & 64'hFFF0_0003;
            if (i == 3) begin
               bk = bk | 64'h2;                                           // R2
               if (b_r[3][39]) continue;                                  // R8
            end
            if (bk[0] == 1'b0) continue;
            mk  = 64'(m_r[i]) & 64'hFFF0_0000;
            ext = mk | 64'hF_FFFF;
            if ((a & ~ext) != (bk & 64'hFFF0_0000)) continue;              // R3
            tb = 64'(t_r[i]) & 64'h7_FFFF_FC00;
            if (bk[1]) begin
               pte_a = (tb & ~(mk >> 10)) | ((a & (mk | 64'hF_E000)) >> 10); // R5
               use_pte = 1;
               table_result(pte_a, a, f, pa);
            end else begin
               f = 0; pa = (tb & ~ext) | (a & ext);                       // R4
            end
            return;
         end
      end else if (ident_en && a >= 64'h100_0000_0000 && a < 64'h200_0000_0000) begin
         f = 0; pa = a & 64'h7_FFFF_FFFF;                                 // R9
      end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF && b_r[3][0] && b_r[3][39]) begin
         pte_a = (64'(t_r[3]) & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10); // R10
         use_pte = 1;
         table_result(pte_a, a, f, pa);
      end
   endfunction

   typedef struct { logic f; logic [63:0] pa; string tag; } exp_t;
   exp_t sbq [$];

   // monitor: compare every result pulse with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && done) begin
         checks++;
         if (sbq.size() == 0) begin
            failures++;
            $display("FAIL R12 unexpected result actual fault=%0b addr=%h expected none", fault, xlat_addr);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            if (fault !== e.f || xlat_addr !== e.pa[PA_W-1:0]) begin
               failures++;
               $display("FAIL %s actual fault=%0b addr=%h expected fault=%0b addr=%h",
                        e.tag, fault, xlat_addr, e.f, e.pa[PA_W-1:0]);
            end
         end
         seen++;
      end
   end

   task automatic issue(input logic [63:0] a, input string tag, input bit poke);
      logic ef; logic [63:0] epa, epte; bit use_pte;
      model(a, ef, epa, use_pte, epte);
      sbq.push_back('{ef, epa, tag});
      pushed++;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a[ADDR_W-1:0];
      @(negedge clk);
      if (poke) begin
         req_addr = a[ADDR_W-1:0] ^ 44'h10_0000;     // stray request while busy
         checks++;
         if (busy !== 1'b1) begin
            failures++;
            $display("FAIL R12 busy during table read actual=%0b expected=1", busy);
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      while (seen < pushed) @(negedge clk);
      if (use_pte) begin
         checks++;
         if (last_mem_addr !== epte[PA_W-1:0]) begin
            failures++;
            $display("FAIL %s R5 entry address actual=%h expected=%h", tag, last_mem_addr, epte[PA_W-1:0]);
         end
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog R12 actual=hung expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      b_r[0] = 40'h00_4000_0001 | 40'h00_000F_FFFC;  m_r[0] = 32'h0FF0_0000 | 32'h000F_FFFF;  t_r[0] = 35'h2_0000_0000;
      b_r[1] = 40'h00_8000_0003;                     m_r[1] = 32'h0;                          t_r[1] = 35'h1_0000_0000 | 35'h3FF;
      b_r[2] = 40'h00_4000_0001;                     m_r[2] = 32'h0;                          t_r[2] = 35'h3_0000_0000;
      b_r[3] = 40'h00_0000_0001;                     m_r[3] = 32'h0;                          t_r[3] = 35'h0_8000_0000;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || mem_req !== 1'b0) begin
         failures++;
         $display("FAIL R12 reset state actual=%0b%0b%0b expected=000", busy, done, mem_req);
      end
      issue(64'h4123_4567, "R4 R1 direct window with stray register bits", 0);
      issue(64'h4000_1234, "R8 window 0 wins over window 2", 0);
      issue(64'h8000_4ABC, "R5 R6 R1 table window valid entry", 0);
      issue(64'h8000_2ABC, "R6 table window invalid entry", 0);
      issue(64'h0001_4000, "R2 last window forced table mode", 0);
      issue(64'h9000_0000, "R3 R11 no window hit", 0);
      issue(64'h8010_4000, "R3 outside narrow mask", 0);
      m_r[1] = 32'h00F0_0000;
      issue(64'h8010_4000, "R3 R5 widened mask hit", 0);
      hole_en = 1'b1;
      issue(64'h0009_4000, "R7 hole blocks last window", 0);
      hole_en = 1'b0;
      issue(64'h0009_4000, "R7 hole off", 0);
      issue(64'h0001_6000, "R12 stray request while busy", 1);
      b_r[0] = 40'h0;
      issue(64'h4000_1234, "R8 window 2 after window 0 disabled", 0);
      b_r[3] = b_r[3] | (40'h1 << 39);
      issue(64'h0001_4000, "R8 wide enable hides last window", 0);
      issue(64'h800_1234_6000, "R10 wide table path", 0);
      issue(64'h805_4321_A123, "R10 wide table path other entry", 0);
      b_r[3] = b_r[3] & ~40'h1;
      issue(64'h800_1234_6000, "R10 wide path needs enable", 0);
      issue(64'h17F_ABCD_1234, "R9 R11 identity off", 0);
      ident_en = 1'b1;
      issue(64'h17F_ABCD_1234, "R9 identity low bits", 0);
      issue(64'h400_0000_0000, "R11 unclaimed high address", 0);
      repeat (8) @(negedge clk);
      checks++;
      if (sbq.size() != 0) begin
         failures++;
         $display("FAIL R12 pending results actual=%0d expected=0", sbq.size());
      end
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule